// File: doc/BRIEF.md
# Parity and CRC concatenated polar encoder

This block turns a short message word into a polar codeword in three steps run in series. First, parity bits are inserted into the message. Each parity bit closes one segment and carries the XOR of the message bits in that segment. Second, a CRC is computed over the message-plus-parity vector and appended to its end. Third, the resulting outer word is spread over the information positions of a length-N input vector. The frozen positions of that vector are zero, and the vector then goes through the polar transform, one butterfly stage per clock.

Two constant parameter masks set the layout. One marks which positions of the data vector carry parity. The other marks which of the N polar positions carry information. A job starts on a one-cycle start strobe. The codeword appears on a parallel output together with a one-cycle done pulse. The encoder accepts no new job until the current one has finished.

Top module: `pcc_polar_enc`

## Requirements
- R1: After reset, done_o is 0 and cw_o is all zeros.
- R2: The data vector has MSG_W+NPAR bits. Its parity slots are the bits set in PAR_MASK; by default these are data positions 4 and 7. Message bits msg_i[0], msg_i[1], … fill the other slots in ascending order. Each parity slot holds the XOR of the message bits placed since the previous parity slot, or since the start of the vector for the first slot.
- R3: A 16-bit CRC with generator x^16+x^15+x^2+1 and an all-zero start value is computed over the data vector, with data bit 0 processed first. The CRC follows the data vector, most significant remainder bit first.
- R4: The outer word (data vector, then CRC) is placed on the set bits of INFO_MASK in ascending position order. By default these are polar positions 7 and 9 to 31. Every other polar position is 0.
- R5: Codeword bit j is the XOR of the polar input bits u[i] over every i for which j is a bitwise submask of i. This is the n-fold Kronecker power of [1 0; 1 1].
- R6: done_o rises exactly MSG_W+NPAR+log2(N)+1 clock cycles after the cycle in which start_i is sampled in the idle state.
- R7: done_o is high for exactly one cycle. cw_o keeps the codeword in the cycle after done_o.
- R8: A start_i that arrives while a job is running is ignored. The running job finishes with its own message and latency, and no second done_o follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| msg_i | input | MSG_W | Message word, sampled with start_i |
| done_o | output | 1 | One-cycle pulse marking a valid codeword |
| cw_o | output | N | Polar codeword |

## Verification
The bench builds the encoder with N=32, a 6-bit message, two parity bits at data positions 4 and 7 (segments of four and two message bits), a 16-bit CRC and 24 information positions. With only six message bits, all 64 messages can be encoded in turn. Each codeword is inverted through the self-inverse transform, so the parity bits, CRC bits and frozen zeros can be checked one by one against long-division and submask arithmetic done in the bench. A start strobe is also issued in the middle of a job to show that it is ignored.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CRC   = 3'd1,
      ST_LOAD  = 3'd2,
      ST_XFORM = 3'd3,
      ST_DONE  = 3'd4
   } pcc_state_t;

endpackage

// File: rtl/pcc_parity_ins.sv
module pcc_parity_ins #(
   parameter int MSG_W = 6,
   parameter int NPAR  = 2,
   parameter logic [MSG_W+NPAR-1:0] PAR_MASK = 8'h90
) (
   input  logic [MSG_W-1:0]      msg_i,
   output logic [MSG_W+NPAR-1:0] data_o
);
   localparam int K0 = MSG_W + NPAR;

   // walk the data slots, inserting segment parity where the mask says so
   always_comb begin
      logic acc;
      int   mi;
      acc    = 1'b0;
      mi     = 0;
      data_o = '0;
      for (int j = 0; j < K0; j++) begin
         if (PAR_MASK[j]) begin
            data_o[j] = acc;
            acc       = 1'b0;
         end else begin
            if (mi < MSG_W) begin
               data_o[j] = msg_i[mi];
               acc       = acc ^ msg_i[mi];
            end
            mi = mi + 1;
         end
      end
   end
endmodule

// File: rtl/pcc_crc_serial.sv
module pcc_crc_serial #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h8005
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic         bit_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] crc_q;
   logic         fb;

   assign fb    = crc_q[W-1] ^ bit_i;
   assign crc_o = crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '0;
      else if (clr_i)  crc_q <= '0;
      else if (en_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   // R3
   crc_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && !bit_i && crc_q == '0) |=> (crc_q == '0));
endmodule

// File: rtl/pcc_polar_xform.sv
module pcc_polar_xform #(
   parameter int N    = 32,
   parameter int LOGN = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [N-1:0]    u_i,
   input  logic            step_i,
   input  logic [LOGN-1:0] stage_i,
   output logic [N-1:0]    x_o
);
   logic [N-1:0] x_q;
   logic [N-1:0] stage_net [LOGN];

   // one butterfly network per stage, span 2^s
   for (genvar s = 0; s < LOGN; s++) begin : g_stage
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (((i >> s) & 1) == 0) begin : g_xor
            assign stage_net[s][i] = x_q[i] ^ x_q[i + (1 << s)];
         end else begin : g_pass
            assign stage_net[s][i] = x_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       x_q <= '0;
      else if (load_i)  x_q <= u_i;
      else if (step_i)  x_q <= stage_net[stage_i];
   end

   assign x_o = x_q;

   // R5
   top_bit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (x_q[N-1] == $past(x_q[N-1])));
endmodule

// File: rtl/pcc_polar_enc.sv
module pcc_polar_enc
   import pcc_pkg::*;
#(
   parameter int N     = 32,
   parameter int MSG_W = 6,
   parameter int NPAR  = 2,
   parameter int CRC_W = 16,
   parameter logic [CRC_W-1:0]      CRC_POLY  = 16'h8005,
   parameter logic [MSG_W+NPAR-1:0] PAR_MASK  = 8'h90,
   parameter logic [N-1:0]          INFO_MASK = 32'hFFFF_FE80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [MSG_W-1:0] msg_i,
   output logic             done_o,
   output logic [N-1:0]     cw_o
);
   localparam int K0   = MSG_W + NPAR;
   localparam int K    = K0 + CRC_W;
   localparam int LOGN = $clog2(N);
   localparam int CNTW = $clog2(K0 + 1);

   // elaboration-time parameter checks
   if ((1 << LOGN) != N) begin : g_bad_n
      $error("N must be a power of two");
   end
   if ($countones(INFO_MASK) != K) begin : g_bad_info
      $error("INFO_MASK must mark MSG_W+NPAR+CRC_W positions");
   end
   if ($countones(PAR_MASK) != NPAR) begin : g_bad_par
      $error("PAR_MASK must mark NPAR positions");
   end
   if (PAR_MASK[K0-1] != 1'b1) begin : g_bad_tail
      $error("last data slot must be a parity slot");
   end

   pcc_state_t      state_q;
   logic [MSG_W-1:0] msg_q;
   logic [CNTW-1:0] cnt_q;
   logic [LOGN-1:0] stage_q;
   logic [K0-1:0]   data_vec;
   logic [CRC_W-1:0] crc;
   logic [K-1:0]    outer;
   logic [N-1:0]    u_vec;
   logic            accept;

   assign accept = (state_q == ST_IDLE) && start_i;

   pcc_parity_ins #(.MSG_W(MSG_W), .NPAR(NPAR), .PAR_MASK(PAR_MASK)) u_par (
      .msg_i  (msg_q),
      .data_o (data_vec)
   );

   pcc_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .en_i  (state_q == ST_CRC),
      .bit_i (data_vec[cnt_q[CNTW-1:0] < CNTW'(K0) ? cnt_q : '0]),
      .crc_o (crc)
   );

   // outer word: data vector then remainder MSB first
   for (genvar j = 0; j < K; j++) begin : g_outer
      if (j < K0) begin : g_data
         assign outer[j] = data_vec[j];
      end else begin : g_rem
         assign outer[j] = crc[CRC_W-1-(j-K0)];
      end
   end

   // spread the outer word over the information positions
   always_comb begin
      int k;
      k     = 0;
      u_vec = '0;
      for (int i = 0; i < N; i++) begin
         if (INFO_MASK[i]) begin
            if (k < K) u_vec[i] = outer[k];
            k = k + 1;
         end
      end
   end

   pcc_polar_xform #(.N(N), .LOGN(LOGN)) u_xf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (state_q == ST_LOAD),
      .u_i     (u_vec),
      .step_i  (state_q == ST_XFORM),
      .stage_i (stage_q),
      .x_o     (cw_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         msg_q   <= '0;
         cnt_q   <= '0;
         stage_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               msg_q   <= msg_i;
               cnt_q   <= '0;
               state_q <= ST_CRC;
            end
            ST_CRC: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNTW'(K0 - 1)) state_q <= ST_LOAD;
            end
            ST_LOAD: begin
               stage_q <= '0;
               state_q <= ST_XFORM;
            end
            ST_XFORM: begin
               stage_q <= stage_q + 1'b1;
               if (stage_q == LOGN'(LOGN - 1)) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o = (state_q == ST_DONE);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> $stable(msg_q));

   // R6
   load_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD) |-> ($past(state_q) == ST_CRC));

   // R6
   done_after_xform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(state_q) == ST_XFORM));
endmodule

// File: tb/pcc_polar_enc_tb.sv
module pcc_polar_enc_tb;
   localparam int N     = 32;
   localparam int MSG_W = 6;
   localparam int NPAR  = 2;
   localparam int CRC_W = 16;
   localparam int K0    = MSG_W + NPAR;
   localparam int K     = K0 + CRC_W;
   localparam int LOGN  = 5;
   localparam int LAT   = K0 + LOGN + 1;
   localparam logic [K0-1:0] PMASK = 8'h90;
   localparam logic [N-1:0]  IMASK = 32'hFFFF_FE80;
   localparam logic [16:0]   GEN   = 17'h18005;

   logic clk = 0, rst_n = 0, start_i = 0;
   logic [MSG_W-1:0] msg_i = '0;
   logic done_o;
   logic [N-1:0] cw_o;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   pcc_polar_enc #(.N(N), .MSG_W(MSG_W), .NPAR(NPAR), .CRC_W(CRC_W),
      .CRC_POLY(16'h8005), .PAR_MASK(PMASK), .INFO_MASK(IMASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_i(msg_i),
      .done_o(done_o), .cw_o(cw_o));

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected outer word from message
   function automatic logic [K-1:0] expect_outer(input logic [MSG_W-1:0] m);
      logic [K0+15:0] d;
      logic acc;
      int mi;
      d = '0; acc = 0; mi = 0;
      for (int j = 0; j < K0; j++) begin
         if (PMASK[j]) begin d[j] = acc; acc = 0; end
         else begin d[j] = m[mi]; acc ^= m[mi]; mi++; end
      end
      expect_outer = '0;
      for (int j = 0; j < K0; j++) expect_outer[j] = d[j];
      for (int j = 0; j < K0; j++)
         if (d[j]) for (int t = 0; t <= 16; t++) d[j+t] ^= GEN[16-t];
      for (int t = 0; t < 16; t++) expect_outer[K0+t] = d[K0+t];
   endfunction

   function automatic logic [N-1:0] kron(input logic [N-1:0] v);
      kron = '0;
      for (int j = 0; j < N; j++)
         for (int i = 0; i < N; i++)
            if ((j & ~i) == 0) kron[j] ^= v[i];
   endfunction

   task automatic run_job(input logic [MSG_W-1:0] m, input bit poke);
      logic [K-1:0] o;
      logic [N-1:0] u, ue, cwe, held;
      logic [K0-1:0] ddat;
      logic [15:0] dcrc, ecrc;
      int cyc, k;
      bit frz_ok;
      o = expect_outer(m);
      ue = '0; k = 0;
      for (int i = 0; i < N; i++) if (IMASK[i]) begin ue[i] = o[k]; k++; end
      cwe = kron(ue);
      @(negedge clk); start_i = 1; msg_i = m;
      @(negedge clk); start_i = 0;
      cyc = 0;
      while (!done_o && cyc < 100) begin
         @(negedge clk); cyc++;
         if (poke && cyc == 3) begin start_i = 1; msg_i = ~m; end
         else start_i = 0;
      end
      start_i = 0;
      check(cyc == LAT, "R6 latency", cyc, LAT);
      check(cw_o == cwe, "R5 codeword", cw_o, cwe);
      u = kron(cw_o);
      frz_ok = ((u & ~IMASK) == '0);
      check(frz_ok, "R4 frozen zero", u & ~IMASK, 0);
      k = 0; ddat = '0; dcrc = '0;
      for (int i = 0; i < N; i++) if (IMASK[i]) begin
         if (k < K0) ddat[k] = u[i]; else dcrc[15-(k-K0)] = u[i];
         k++;
      end
      check(ddat == o[K0-1:0], "R2 data vector", ddat, o[K0-1:0]);
      for (int t = 0; t < 16; t++) ecrc[15-t] = o[K0+t];
      check(dcrc == ecrc, "R3 crc", dcrc, ecrc);
      held = cw_o;
      @(negedge clk);
      check(!done_o && cw_o == held, "R7 pulse/hold", {done_o, cw_o}, {1'b0, held});
      if (poke) begin
         for (int w = 0; w < LAT + 4; w++) begin
            @(negedge clk);
            check(!done_o, "R8 no second job", done_o, 0);
         end
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done_o == 0 && cw_o == '0, "R1 reset", {done_o, cw_o}, 0);
      rst_n = 1;
      @(negedge clk);
      check(done_o == 0 && cw_o == '0, "R1 idle", {done_o, cw_o}, 0);
      for (int m = 0; m < (1 << MSG_W); m++) run_job(MSG_W'(m), 1'b0);
      run_job(6'h2d, 1'b1);
      run_job(6'h00, 1'b1);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule